// File: doc/BRIEF.md
# Windowed Address Router

This block connects one upstream requester to four memory-like targets. Each target owns a window of the upstream address space. A window is set by a base address and a span, and both are written through a small configuration port. When an upstream access falls inside a window, the block subtracts that window's base from the address. The target then sees a local address that counts from zero.

Windows may overlap. A read is answered by the lowest-numbered window that contains the address. A write goes to every window that contains it, all in the same cycle. Each target reports how many locations it really has, and the router compares the local address against that limit. A read inside a window but past the target's limit returns zero and raises no error. A write there is dropped quietly. Target locations that lie beyond a window's span cannot be reached through the router. An address that no window covers is answered with an error.

The response comes one cycle after each request: a valid pulse, an error flag and the read data, all from registers.

Top module: `win_addr_router`

## Requirements
- R1: After reset every window is disabled, no target strobe is active, and `rsp_valid`, `rsp_err` and `rsp_rdata` are all zero.
- R2: A configuration write to window `cfg_port` takes effect from the next clock edge. An access presented in the same cycle as the configuration write is decoded with the previous window settings.
- R3: Address `a` matches window `i` when `span[i] != 0`, `a >= base[i]` and `a - base[i] < span[i]`. The target then sees `dn_addr` slice `i` equal to `a - base[i]`.
- R4: A request that matches no window produces `rsp_err = 1` and `rsp_rdata = 0` with the response one cycle later, and no target is strobed.
- R5: A read strobes only the lowest-numbered matching window, with `dn_we` low. The next cycle's `rsp_rdata` equals that target's `dn_rdata` at the local address.
- R6: A read whose lowest-numbered match has a local address at or above that target's `dn_limit` returns `rsp_rdata = 0` with `rsp_err = 0`, and no target is strobed.
- R7: A write strobes `dn_sel` and `dn_we` on every matching window whose local address is below its limit, all in the same cycle, and puts `up_wdata` on each of them.
- R8: A write whose local address is at or above a matching target's limit does not strobe that target and raises no error.
- R9: A window whose span is 0 never matches.
- R10: `rsp_valid` pulses exactly one cycle after every `up_valid`. A write response carries `rsp_rdata = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PW | Window being configured |
| cfg_base | input | AW | New base address for the window |
| cfg_span | input | AW | New span for the window (0 disables it) |
| up_valid | input | 1 | Upstream request valid |
| up_we | input | 1 | Upstream request is a write |
| up_addr | input | AW | Upstream address |
| up_wdata | input | DW | Upstream write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | The address matched no window |
| rsp_rdata | output | DW | Read data |
| dn_sel | output | NP | Per-target access strobe |
| dn_we | output | NP | Per-target write strobe |
| dn_addr | output | NP*AW | Per-target local address |
| dn_wdata | output | NP*DW | Per-target write data |
| dn_rdata | input | NP*DW | Per-target read data, combinational from the local address |
| dn_limit | input | NP*AW | Per-target real size in locations |

## Verification
Two functions can fall in the same cycle: a configuration update and an access that the update would re-route. The bench provokes this by moving a window's base in the same cycle as a read of the old base. It judges the result by the target strobed and the data returned, which must follow the old window. A follow-up read at the old base must then fail, and one at the new base must succeed. Write fan-out and read priority also meet on the overlapping range. Writes there are checked for strobes on both targets, and reads there for data from the lower-numbered target only.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

   typedef enum logic [1:0] {
      RK_IDLE  = 2'd0,
      RK_DATA  = 2'd1,
      RK_ZERO  = 2'd2,
      RK_FAULT = 2'd3
   } rtr_kind_e;

   localparam int unsigned RTR_MAX_PORTS = 32;

   // isolate lowest set bit
   function automatic logic [RTR_MAX_PORTS-1:0] rtr_lowest(input logic [RTR_MAX_PORTS-1:0] v);
      return v & (~v + 1'b1);
   endfunction

endpackage

// File: rtl/rtr_cfg_bank.sv
module rtr_cfg_bank #(
   parameter int NP = 4,
   parameter int AW = 16,
   parameter int PW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [PW-1:0]  wr_port,
   input  logic [AW-1:0]  wr_base,
   input  logic [AW-1:0]  wr_span,
   output logic [NP*AW-1:0] base_flat,
   output logic [NP*AW-1:0] span_flat
);

   for (genvar i = 0; i < NP; i++) begin : g_win
      logic [AW-1:0] base_q, span_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            span_q <= '0;
         end else if (wr_en && (int'(wr_port) == i)) begin
            base_q <= wr_base;
            span_q <= wr_span;
         end
      end
      assign base_flat[i*AW +: AW] = base_q;
      assign span_flat[i*AW +: AW] = span_q;
   end

   // R2: settings change only on a configuration write
   a_r2_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(base_flat) && $stable(span_flat)));

endmodule

// File: rtl/rtr_window.sv
module rtr_window #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] span,
   input  logic [AW-1:0] limit,
   output logic          hit,
   output logic          in_limit,
   output logic [AW-1:0] local_addr
);

   logic above;

   always_comb begin
      local_addr = addr - base;
      above      = (addr >= base);
      hit        = (span != '0) && above && (local_addr < span);
      in_limit   = (local_addr < limit);
   end

endmodule

// File: rtl/rtr_resp.sv
module rtr_resp
   import rtr_pkg::*;
#(
   parameter int NP = 4,
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_we,
   input  logic [NP-1:0]    hit,
   input  logic [NP-1:0]    in_lim,
   input  logic [NP*DW-1:0] port_rdata,
   output logic [NP-1:0]    first,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [DW-1:0]    rsp_rdata
);

   logic [RTR_MAX_PORTS-1:0] low_v;
   logic [DW-1:0]            sel_data;
   rtr_kind_e                kind;

   always_comb begin
      low_v = rtr_lowest(RTR_MAX_PORTS'(hit));
      first = low_v[NP-1:0];
   end

   always_comb begin
      sel_data = '0;
      for (int i = 0; i < NP; i++) begin
         if (first[i] && in_lim[i]) sel_data = sel_data | port_rdata[i*DW +: DW];
      end
   end

   always_comb begin
      if (!req_valid)                 kind = RK_IDLE;
      else if (hit == '0)             kind = RK_FAULT;
      else if (req_we)                kind = RK_ZERO;
      else if ((first & in_lim) != '0) kind = RK_DATA;
      else                            kind = RK_ZERO;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= (kind != RK_IDLE);
         rsp_err   <= (kind == RK_FAULT);
         rsp_rdata <= (kind == RK_DATA) ? sel_data : '0;
      end
   end

   // R10: one response per request, none otherwise
   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_err));
   // R4: an error response never carries data
   a_r4_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));
   // R10: write responses carry no data
   a_r10_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we) |=> (rsp_rdata == '0));

endmodule

// File: rtl/win_addr_router.sv
module win_addr_router #(
   parameter int NP = 4,
   parameter int AW = 16,
   parameter int DW = 16,
   localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [PW-1:0]    cfg_port,
   input  logic [AW-1:0]    cfg_base,
   input  logic [AW-1:0]    cfg_span,
   input  logic             up_valid,
   input  logic             up_we,
   input  logic [AW-1:0]    up_addr,
   input  logic [DW-1:0]    up_wdata,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [DW-1:0]    rsp_rdata,
   output logic [NP-1:0]    dn_sel,
   output logic [NP-1:0]    dn_we,
   output logic [NP*AW-1:0] dn_addr,
   output logic [NP*DW-1:0] dn_wdata,
   input  logic [NP*DW-1:0] dn_rdata,
   input  logic [NP*AW-1:0] dn_limit
);

   if (NP < 1 || NP > rtr_pkg::RTR_MAX_PORTS) begin : g_bad_np
      $error("win_addr_router: NP out of range");
   end
   if (AW < 2) begin : g_bad_aw
      $error("win_addr_router: AW too small");
   end
   if (DW < 1) begin : g_bad_dw
      $error("win_addr_router: DW too small");
   end

   logic [NP*AW-1:0] base_flat, span_flat;
   logic [NP-1:0]    hit, in_lim, first;

   rtr_cfg_bank #(.NP(NP), .AW(AW), .PW(PW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_port   (cfg_port),
      .wr_base   (cfg_base),
      .wr_span   (cfg_span),
      .base_flat (base_flat),
      .span_flat (span_flat)
   );

   for (genvar i = 0; i < NP; i++) begin : g_port
      rtr_window #(.AW(AW)) u_win (
         .addr       (up_addr),
         .base       (base_flat[i*AW +: AW]),
         .span       (span_flat[i*AW +: AW]),
         .limit      (dn_limit[i*AW +: AW]),
         .hit        (hit[i]),
         .in_limit   (in_lim[i]),
         .local_addr (dn_addr[i*AW +: AW])
      );
      assign dn_sel[i] = up_valid & in_lim[i] & (up_we ? hit[i] : first[i]);
      assign dn_we[i]  = up_we & dn_sel[i];
      assign dn_wdata[i*DW +: DW] = up_wdata;
   end

   rtr_resp #(.NP(NP), .DW(DW)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (up_valid),
      .req_we     (up_we),
      .hit        (hit),
      .in_lim     (in_lim),
      .port_rdata (dn_rdata),
      .first      (first),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata)
   );

   // R1: no strobes without a request
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |-> (dn_sel == '0));
   // R5: a read touches at most one target
   a_r5_read_single: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_we) |-> $onehot0(dn_sel));
   // R7: write strobe only with access strobe
   a_r7_we_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_we & ~dn_sel) == '0);
   // R4: an error follows a cycle without strobes
   a_r4_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && hit == '0) |=> rsp_err);

endmodule

// File: tb/tb_win_addr_router.sv
`timescale 1ns/1ps
module tb_win_addr_router;
   localparam int NP = 4;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int PW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [PW-1:0] cfg_port = '0;
   logic [AW-1:0] cfg_base = '0, cfg_span = '0;
   logic up_valid = 1'b0, up_we = 1'b0;
   logic [AW-1:0] up_addr = '0;
   logic [DW-1:0] up_wdata = '0;
   logic rsp_valid, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic [NP-1:0] dn_sel, dn_we;
   logic [NP*AW-1:0] dn_addr;
   logic [NP*DW-1:0] dn_wdata;
   logic [NP*DW-1:0] dn_rdata;
   logic [NP*AW-1:0] dn_limit;

   always #5 clk = ~clk;

   win_addr_router #(.NP(NP), .AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_base(cfg_base), .cfg_span(cfg_span),
      .up_valid(up_valid), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .dn_sel(dn_sel), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
      .dn_rdata(dn_rdata), .dn_limit(dn_limit)
   );

   // target models
   logic [DW-1:0] mem [NP][64];
   int lim_m [NP] = '{32, 64, 16, 64};
   assign dn_limit = {16'(lim_m[3]), 16'(lim_m[2]), 16'(lim_m[1]), 16'(lim_m[0])};

   always_comb begin
      for (int i = 0; i < NP; i++) dn_rdata[i*DW +: DW] = mem[i][dn_addr[i*AW +: 6]];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NP; i++)
            for (int j = 0; j < 64; j++) mem[i][j] <= 16'h1000 + 16'(i * 256 + j);
      end else begin
         for (int i = 0; i < NP; i++)
            if (dn_sel[i] && dn_we[i]) mem[i][dn_addr[i*AW +: 6]] <= dn_wdata[i*DW +: DW];
      end
   end

   // bench model of windows
   int base_m [NP] = '{0, 0, 0, 0};
   int span_m [NP] = '{0, 0, 0, 0};

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // compute expectation and run one access
   task automatic access(input string tag, input bit we, input int a, input int d,
                         input bit with_cfg = 0, input int cp = 0, input int cb = 0, input int cs = 0);
      bit [NP-1:0] h, inl, esel;
      bit [AW-1:0] loc [NP];
      bit any;
      int f;
      bit [DW-1:0] erd;
      f = -1;
      erd = '0;
      for (int i = 0; i < NP; i++) begin
         loc[i] = AW'(a - base_m[i]);
         h[i]   = (span_m[i] != 0) && (a >= base_m[i]) && (int'(loc[i]) < span_m[i]);
         inl[i] = int'(loc[i]) < lim_m[i];
         if (h[i] && f < 0) f = i;
      end
      any = (h != '0);
      esel = '0;
      if (we) esel = h & inl;
      else if (f >= 0 && inl[f]) begin
         esel[f] = 1'b1;
         erd = mem[f][loc[f][5:0]];
      end
      @(negedge clk);
      up_valid = 1'b1; up_we = we; up_addr = AW'(a); up_wdata = DW'(d);
      if (with_cfg) begin
         cfg_we = 1'b1; cfg_port = PW'(cp); cfg_base = AW'(cb); cfg_span = AW'(cs);
      end
      #1;
      chk(dn_sel == esel, tag, "dn_sel", int'(dn_sel), int'(esel));
      chk(dn_we == (we ? esel : '0), tag, "dn_we", int'(dn_we), int'(we ? esel : '0));
      for (int i = 0; i < NP; i++) if (esel[i]) begin
         chk(dn_addr[i*AW +: AW] == loc[i], tag, "dn_addr", int'(dn_addr[i*AW +: AW]), int'(loc[i]));
         if (we) chk(dn_wdata[i*DW +: DW] == DW'(d), tag, "dn_wdata", int'(dn_wdata[i*DW +: DW]), d);
      end
      @(negedge clk);
      up_valid = 1'b0; up_we = 1'b0; cfg_we = 1'b0;
      if (with_cfg) begin
         base_m[cp] = cb; span_m[cp] = cs;
      end
      chk(rsp_valid == 1'b1, "R10", "rsp_valid", int'(rsp_valid), 1);
      chk(rsp_err == !any, tag, "rsp_err", int'(rsp_err), int'(!any));
      chk(rsp_rdata == ((we || !any) ? '0 : erd), tag, "rsp_rdata", int'(rsp_rdata),
          int'((we || !any) ? '0 : erd));
      #1;
      chk(rsp_valid == 1'b1, "R10", "rsp_valid held", int'(rsp_valid), 1);
   endtask

   task automatic set_win(input int p, input int b, input int s);
      @(negedge clk);
      cfg_we = 1'b1; cfg_port = PW'(p); cfg_base = AW'(b); cfg_span = AW'(s);
      @(negedge clk);
      cfg_we = 1'b0;
      base_m[p] = b; span_m[p] = s;
      chk(rsp_valid == 1'b0, "R10", "no rsp when idle", int'(rsp_valid), 0);
   endtask

   task automatic t_reset;
      chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
      chk(rsp_err == 1'b0, "R1", "rsp_err", int'(rsp_err), 0);
      chk(rsp_rdata == '0, "R1", "rsp_rdata", int'(rsp_rdata), 0);
      chk(dn_sel == '0, "R1", "dn_sel", int'(dn_sel), 0);
      access("R1", 1'b0, 0, 0);          // all windows off: error
      chk(rsp_err == 1'b1, "R9", "disabled after reset", int'(rsp_err), 1);
   endtask

   task automatic t_setup;
      set_win(0, 0, 32);
      set_win(1, 16, 64);
      set_win(2, 100, 32);
      set_win(3, 200, 8);
   endtask

   task automatic t_basic;
      access("R7", 1'b1, 5, 16'hA5A5);
      access("R5", 1'b0, 5, 0);
      chk(rsp_rdata == 16'hA5A5, "R3", "readback", int'(rsp_rdata), 16'hA5A5);
      access("R3", 1'b0, 40, 0);         // window 1 local 24
   endtask

   task automatic t_overlap;
      access("R5", 1'b0, 20, 0);          // both match, window 0 answers
      chk(rsp_rdata == 16'h1014, "R5", "lowest wins", int'(rsp_rdata), 16'h1014);
      access("R7", 1'b1, 22, 16'hBEEF);   // both strobed
      access("R7", 1'b0, 22, 0);
      chk(rsp_rdata == 16'hBEEF, "R7", "overlap write", int'(rsp_rdata), 16'hBEEF);
   endtask

   task automatic t_beyond;
      access("R6", 1'b0, 120, 0);         // local 20 past limit 16
      chk(rsp_err == 1'b0 && rsp_rdata == '0, "R6", "zero no err", int'(rsp_rdata), 0);
      access("R8", 1'b1, 120, 16'h7777);
      access("R3", 1'b0, 205, 0);         // window 3 local 5
      access("R3", 1'b0, 208, 0);         // beyond span 8: unreachable
   endtask

   task automatic t_miss;
      access("R4", 1'b1, 90, 16'h1234);
      access("R4", 1'b0, 150, 0);
   endtask

   task automatic t_zero_span;
      set_win(3, 200, 0);
      access("R9", 1'b0, 205, 0);
   endtask

   task automatic t_cfg_race;
      access("R2", 1'b0, 100, 0, 1'b1, 2, 300, 32);  // old window still used
      chk(rsp_rdata == 16'h1200, "R2", "old window data", int'(rsp_rdata), 16'h1200);
      access("R2", 1'b0, 100, 0);
      access("R2", 1'b0, 301, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_setup();
      t_basic();
      t_overlap();
      t_beyond();
      t_miss();
      t_zero_span();
      t_cfg_race();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule